// File: doc/BRIEF.md
# Triple-Buffer Frame Swap Controller

This block coordinates three frame buffers in external memory that a video writer and a video reader share while running on unrelated frame cadences. At any moment one buffer belongs to the writer, one to the reader, and the third is held in reserve. The reserve buffer carries a single status bit: it is either *fresh* (holding a complete frame that the reader has not yet taken) or *consumed* (safe for the writer to take over).

Each side reports the end of a frame with a one-cycle strobe. The writer trades its buffer for the reserve only when the reserve is consumed; otherwise its finished frame is discarded and it overwrites the same buffer. The reader trades only when the reserve is fresh; otherwise it replays the frame it already has. The block gives each side the base address of its current buffer, the buffer index, and a one-cycle pulse whenever that side takes the non-swap path. The memory masters use the base addresses; the pixel path lies outside this block.

Top module: `fbuf_swap_ctrl`

## Requirements
- R1: After reset the write buffer is index 0, the read buffer is index 1, the reserve is index 2 and is consumed, and both pulse outputs are low.
- R2: A write end-of-frame while the reserve is consumed exchanges the write and reserve indices and marks the reserve fresh. The new indices appear on the outputs one clock after the strobe.
- R3: A write end-of-frame while the reserve is fresh leaves the write index unchanged and raises `wrDrop` for exactly the one cycle after the strobe.
- R4: A read end-of-frame while the reserve is fresh exchanges the read and reserve indices and marks the reserve consumed. The change appears one clock after the strobe.
- R5: A read end-of-frame while the reserve is consumed leaves the read index unchanged and raises `rdRepeat` for exactly the one cycle after the strobe.
- R6: When both strobes arrive in the same cycle, the write decision is applied first, and the read decision uses the reserve status that results from it.
- R7: The base address of buffer i is REGION_BASE rounded up to ALIGN, plus i times FRAME_BYTES rounded up to ALIGN. ALIGN is the larger of WR_BURST and RD_BURST. With the defaults (0x80, 1000, 64, 256) the bases are 0x100, 0x500 and 0x900, and every base is a multiple of ALIGN.
- R8: The write and read indices are always distinct and lie in 0..2.
- R9: With the writer finishing a frame every 5 cycles and the reader every 6 cycles, about one written frame in six is dropped.
- R10: `wrDrop` and `rdRepeat` are raised only in the cycle that follows the matching end-of-frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrFrameDone | input | 1 | One-cycle strobe: the writer has finished a frame |
| rdFrameDone | input | 1 | One-cycle strobe: the reader has finished a frame |
| wrIdx | output | 2 | Buffer index the writer currently owns |
| rdIdx | output | 2 | Buffer index the reader currently owns |
| wrBase | output | ADDR_W | Base address of the write buffer |
| rdBase | output | ADDR_W | Base address of the read buffer |
| wrDrop | output | 1 | One-cycle pulse: the finished written frame was discarded |
| rdRepeat | output | 1 | One-cycle pulse: the reader will replay its frame |

## Verification
The write-side and read-side end-of-frame decisions can fall in the same cycle, and both touch the one reserve status bit. Directed cycles raise both strobes together, once with the reserve consumed and once with it fresh, so that both the write-swap-then-read-swap chain and the drop-plus-read-swap case occur. Random stimulus also makes coincident strobes often. A bench model applies the write step before the read step and compares indices, bases and pulses every cycle.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  localparam int NUM_BUF = 3;
  typedef logic [1:0] bufIdx_t;

  typedef struct packed {
    logic wrSwap;
    logic rdSwap;
  } swapStrobe_t;

  function automatic int unsigned roundUp(input int unsigned val, input int unsigned mult);
    return ((val + mult - 1) / mult) * mult;
  endfunction
endpackage

// File: rtl/fbuf_swap_ctl.sv
module fbuf_swap_ctl
  import fbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrFrameDone,
  input  logic        rdFrameDone,
  output swapStrobe_t strobe,
  output logic        wrDrop,
  output logic        rdRepeat
);
  logic spareFresh;
  logic freshAfterWr;
  logic freshNext;

  // Write step first, then read step sees the result.
  always_comb begin
    strobe.wrSwap = wrFrameDone && !spareFresh;
    freshAfterWr  = strobe.wrSwap ? 1'b1 : spareFresh;
    strobe.rdSwap = rdFrameDone && freshAfterWr;
    freshNext     = strobe.rdSwap ? 1'b0 : freshAfterWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spareFresh <= 1'b0;
      wrDrop     <= 1'b0;
      rdRepeat   <= 1'b0;
    end else begin
      spareFresh <= freshNext;
      wrDrop     <= wrFrameDone && spareFresh;
      rdRepeat   <= rdFrameDone && !freshAfterWr;
    end
  end
endmodule

// File: rtl/fbuf_addr_dp.sv
module fbuf_addr_dp
  import fbuf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int unsigned BASE_AL  = 256,
  parameter int unsigned FRAME_AL = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapStrobe_t       strobe,
  output bufIdx_t           wrIdx,
  output bufIdx_t           rdIdx,
  output logic [ADDR_W-1:0] wrBase,
  output logic [ADDR_W-1:0] rdBase
);
  bufIdx_t spIdx;
  bufIdx_t wrNext, rdNext, spNext;
  logic [ADDR_W-1:0] baseTab [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : gBase
    assign baseTab[g] = ADDR_W'(BASE_AL + g * FRAME_AL);
  end

  function automatic logic [ADDR_W-1:0] pickBase(input bufIdx_t idx);
    case (idx)
      2'd1:    return baseTab[1];
      2'd2:    return baseTab[2];
      default: return baseTab[0];
    endcase
  endfunction

  always_comb begin
    wrNext = wrIdx;
    rdNext = rdIdx;
    spNext = spIdx;
    unique case ({strobe.wrSwap, strobe.rdSwap})
      2'b11: begin wrNext = spIdx; rdNext = wrIdx; spNext = rdIdx; end
      2'b10: begin wrNext = spIdx; spNext = wrIdx; end
      2'b01: begin rdNext = spIdx; spNext = rdIdx; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx  <= 2'd0;
      rdIdx  <= 2'd1;
      spIdx  <= 2'd2;
      wrBase <= baseTab[0];
      rdBase <= baseTab[1];
    end else begin
      wrIdx  <= wrNext;
      rdIdx  <= rdNext;
      spIdx  <= spNext;
      wrBase <= pickBase(wrNext);
      rdBase <= pickBase(rdNext);
    end
  end
endmodule

// File: rtl/fbuf_swap_ctrl.sv
module fbuf_swap_ctrl
  import fbuf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BASE = 32'h80,
  parameter int FRAME_BYTES = 1000,
  parameter int WR_BURST    = 64,
  parameter int RD_BURST    = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrFrameDone,
  input  logic              rdFrameDone,
  output logic [1:0]        wrIdx,
  output logic [1:0]        rdIdx,
  output logic [ADDR_W-1:0] wrBase,
  output logic [ADDR_W-1:0] rdBase,
  output logic              wrDrop,
  output logic              rdRepeat
);
  localparam int unsigned ALIGN    = (WR_BURST > RD_BURST) ? WR_BURST : RD_BURST;
  localparam int unsigned BASE_AL  = roundUp(REGION_BASE, ALIGN);
  localparam int unsigned FRAME_AL = roundUp(FRAME_BYTES, ALIGN);

  swapStrobe_t strobe;

  fbuf_swap_ctl uCtl (
    .clk(clk), .rstN(rstN),
    .wrFrameDone(wrFrameDone), .rdFrameDone(rdFrameDone),
    .strobe(strobe), .wrDrop(wrDrop), .rdRepeat(rdRepeat)
  );

  fbuf_addr_dp #(.ADDR_W(ADDR_W), .BASE_AL(BASE_AL), .FRAME_AL(FRAME_AL)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .wrBase(wrBase), .rdBase(rdBase)
  );
endmodule

// File: rtl/fbuf_swap_chk.sv
module fbuf_swap_chk #(
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrFrameDone,
  input logic              rdFrameDone,
  input logic [1:0]        wrIdx,
  input logic [1:0]        rdIdx,
  input logic [ADDR_W-1:0] wrBase,
  input logic [ADDR_W-1:0] rdBase,
  input logic              wrDrop,
  input logic              rdRepeat
);
  a_r8_idx_distinct: assert property (@(posedge clk) disable iff (!rstN)
    (wrIdx != rdIdx) && (wrIdx < 2'd3) && (rdIdx < 2'd3));

  a_r3_drop_holds_idx: assert property (@(posedge clk) disable iff (!rstN)
    wrDrop |-> wrIdx == $past(wrIdx));

  a_r2_wr_swap_moves: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrFrameDone) && !wrDrop) |-> wrIdx != $past(wrIdx));

  a_r5_repeat_holds_idx: assert property (@(posedge clk) disable iff (!rstN)
    rdRepeat |-> rdIdx == $past(rdIdx));

  a_r4_rd_swap_moves: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdFrameDone) && !rdRepeat) |-> rdIdx != $past(rdIdx));

  a_r10_drop_after_done: assert property (@(posedge clk) disable iff (!rstN)
    wrDrop |-> $past(wrFrameDone));

  a_r10_repeat_after_done: assert property (@(posedge clk) disable iff (!rstN)
    rdRepeat |-> $past(rdFrameDone));

  a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ((wrBase % ADDR_W'(ALIGN_BYTES)) == '0) && ((rdBase % ADDR_W'(ALIGN_BYTES)) == '0));
endmodule

bind fbuf_swap_ctrl fbuf_swap_chk #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN)) uChk (
  .clk(clk), .rstN(rstN), .wrFrameDone(wrFrameDone), .rdFrameDone(rdFrameDone),
  .wrIdx(wrIdx), .rdIdx(rdIdx), .wrBase(wrBase), .rdBase(rdBase),
  .wrDrop(wrDrop), .rdRepeat(rdRepeat)
);

// File: tb/sim_fbuf_swap_ctrl.sv
module sim_fbuf_swap_ctrl;
  localparam int ADDR_W = 32;
  localparam int RB = 32'h80, FB = 1000, WB = 64, RDB = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrFrameDone = 1'b0, rdFrameDone = 1'b0;
  logic [1:0] wrIdx, rdIdx;
  logic [ADDR_W-1:0] wrBase, rdBase;
  logic wrDrop, rdRepeat;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int mWr, mRd, mSp;
  bit mFresh, eDrop, eRep;
  int dropCnt, wrCnt;

  always #5 clk = ~clk;

  fbuf_swap_ctrl #(.ADDR_W(ADDR_W), .REGION_BASE(RB), .FRAME_BYTES(FB),
                   .WR_BURST(WB), .RD_BURST(RDB)) u0 (
    .clk(clk), .rstN(rstN), .wrFrameDone(wrFrameDone), .rdFrameDone(rdFrameDone),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .wrBase(wrBase), .rdBase(rdBase),
    .wrDrop(wrDrop), .rdRepeat(rdRepeat)
  );

  function automatic int expBase(input int idx);
    int al = (WB > RDB) ? WB : RDB;
    int b0 = ((RB + al - 1) / al) * al;
    int fs = ((FB + al - 1) / al) * al;
    return b0 + idx * fs;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "wrIdx", wrIdx, mWr);
    check(req, "rdIdx", rdIdx, mRd);
    check("R7", "wrBase", wrBase, expBase(mWr));
    check("R7", "rdBase", rdBase, expBase(mRd));
    check(req, "wrDrop", wrDrop, eDrop);
    check(req, "rdRepeat", rdRepeat, eRep);
  endtask

  // drive at negedge, sample at following negedge
  task automatic step(input bit w, input bit r, input string req);
    int t;
    wrFrameDone = w;
    rdFrameDone = r;
    eDrop = 0; eRep = 0;
    if (w) begin
      wrCnt++;
      if (!mFresh) begin t = mWr; mWr = mSp; mSp = t; mFresh = 1; end
      else begin eDrop = 1; dropCnt++; end
    end
    if (r) begin
      if (mFresh) begin t = mRd; mRd = mSp; mSp = t; mFresh = 0; end
      else eRep = 1;
    end
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    mWr = 0; mRd = 1; mSp = 2; mFresh = 0; eDrop = 0; eRep = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkAll("R1");
    check("R7", "base0", wrBase, 32'h100);
    check("R7", "base1", rdBase, 32'h500);
    // R5 read with consumed reserve
    step(0, 1, "R5");
    step(0, 0, "R10");
    // R2 write with consumed reserve
    step(1, 0, "R2");
    check("R7", "base2", wrBase, 32'h900);
    // R3 write with fresh reserve
    step(1, 0, "R3");
    step(0, 0, "R10");
    // R4 read with fresh reserve
    step(0, 1, "R4");
    // R6 both, reserve consumed: write swap then read swap
    step(1, 1, "R6");
    // make reserve fresh, then both: drop plus read swap
    step(1, 0, "R2");
    step(1, 1, "R6");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int v = $urandom % 8;
      step(v[0] && v[1], v[2] && v[0] == 1'b0 ? 1'b1 : v[2], "R8");
    end
    // R9 rate: writer every 5, reader every 6
    dropCnt = 0; wrCnt = 0;
    for (int c = 1; c <= 600; c++) step((c % 5) == 0, (c % 6) == 0, "R9");
    checks++;
    if (dropCnt * 6 < wrCnt - 18 || dropCnt * 6 > wrCnt + 18) begin
      errors++;
      $display("FAIL R9 drops actual=%0d expected=%0d", dropCnt, wrCnt / 6);
    end
    wrFrameDone = 0; rdFrameDone = 0;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule